// File: doc/BRIEF.md
# Flash Self-Programming Access Controller

This controller sits between a small processor core and its on-chip program flash and decides what happens when running code asks to erase or write a flash page. A store request is honoured only when the program counter lies in the boot-loader region at the top of the flash. The size of that region comes from a 2-bit setting. Once a store is accepted, a timer models the erase/write time. Meanwhile the controller decides whether the core stalls or keeps fetching. That depends on which fixed half of the flash is being programmed: the lower part (which the core may keep reading around) or the upper part (which stalls the core).

Instruction reads pass through the controller with one cycle of latency. A read is returned as data, or as an invalid word (all ones) when one of these applies: the core is stalled, the lower fixed region is hidden, or a lock setting forbids the access. Each of the two regions (application and boot loader) has its own 2-bit lock. One bit of the lock gates stores into that region. The other bit gates reads into it from code in the other region. After an operation on the lower fixed region, that region stays hidden until boot-loader code issues a re-enable command.

Top module: `flash_spm_guard`

## Requirements
- R1: The boot-loader region is the top 128, 256, 512 or 1024 words of the 4096-word flash for boot_size 2'b11, 2'b10, 2'b01 or 2'b00. A store request made while idle with pc inside that region and an open store lock raises st_grant for one cycle, on the cycle after the request.
- R2: A store request made while pc lies below the boot-loader region is ignored: no st_grant, no busy, no violation.
- R3: An accepted store may target any address, including addresses inside the boot-loader region.
- R4: After a grant, busy stays high for exactly BUSY_CYCLES cycles. A store request made while busy is high raises st_err for one cycle and leaves the running operation unchanged.
- R5: During an operation whose target is below word 0xC00, cpu_stall stays low and reads at 0xC00 or above return the flash data with rd_valid high.
- R6: During an operation whose target is at 0xC00 or above, cpu_stall is high for the whole operation and every read returns rd_valid low with rd_data 16'hFFFF and no violation.
- R7: From the grant of a store below 0xC00 onward, reads below 0xC00 return rd_valid low and 16'hFFFF with no violation. This continues after the operation ends, until a re-enable is accepted.
- R8: A re-enable request is accepted only when pc is inside the boot-loader region and busy is low. Reads below 0xC00 are served again from the next cycle. A re-enable from the application region, or made while busy, has no effect.
- R9: Lock bit 0 of a region (app_lock or boot_lock) at 0 blocks stores into that region. Such a request from the boot-loader region raises violation for one cycle and gives no grant.
- R10: Lock bit 1 of a region at 0 blocks reads of that region by code running in the other region. Such a read returns rd_valid low and 16'hFFFF, and raises violation for one cycle. Reads from within the same region are unaffected.
- R11: A read result appears on rd_valid and rd_data on the cycle after rd_req. With no request, rd_valid is low and rd_data is 16'hFFFF.
- R12: After reset, busy, cpu_stall, st_grant, st_err, rd_valid and violation are low, rd_data is 16'hFFFF and the lower region is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | ADDR_W | Word address of the executing instruction |
| boot_size | input | 2 | Boot-loader region size setting |
| app_lock | input | 2 | Application region lock: bit 1 read open, bit 0 store open |
| boot_lock | input | 2 | Boot-loader region lock: bit 1 read open, bit 0 store open |
| st_req | input | 1 | Page erase/write request |
| st_addr | input | ADDR_W | Target word address of the store |
| reen_req | input | 1 | Re-enable reads of the lower fixed region |
| rd_req | input | 1 | Instruction read request |
| rd_addr | input | ADDR_W | Read word address |
| flash_data | input | DATA_W | Array data for rd_addr, same cycle |
| st_grant | output | 1 | Store accepted (one-cycle pulse) |
| st_err | output | 1 | Store rejected because busy (one-cycle pulse) |
| busy | output | 1 | Erase/write in progress |
| cpu_stall | output | 1 | Core must stall |
| rd_valid | output | 1 | rd_data holds flash data |
| rd_data | output | DATA_W | Read result, all ones when invalid |
| violation | output | 1 | Lock violation (one-cycle pulse) |

## Verification
The hardest state to reach is the lower region still hidden after its operation has finished. Reaching it takes a granted store below 0xC00, the full busy time, and then re-enable attempts that must fail before one succeeds. The stimulus walks that path step by step: a re-enable from application code, then one made while busy, then one from the boot region. Between the attempts it reads the lower region. A randomized phase then mixes overlapping stores, reads, re-enables and lock changes, with pc biased into the boot region so that grants happen often.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // per-region lock: bit 1 cross-region reads open, bit 0 stores open
  typedef struct packed {
    logic rd_open;
    logic wr_open;
  } fg_lock_t;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_OK,
    RD_HIDDEN,
    RD_DENIED
  } fg_rd_e;
endpackage

// File: rtl/fg_region_decode.sv
module fg_region_decode #(
  parameter int ADDR_W   = 12,
  parameter int BOOT_MIN = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        boot_size,
  output logic              in_boot
);
  localparam int unsigned SPAN = 1 << ADDR_W;

  logic [ADDR_W:0] boot_words;
  logic [ADDR_W:0] boot_base;

  always_comb begin
    boot_words = (ADDR_W+1)'(BOOT_MIN) << (~boot_size);
    boot_base  = (ADDR_W+1)'(SPAN) - boot_words;
    in_boot    = {1'b0, addr} >= boot_base;
  end
endmodule

// File: rtl/fg_busy_timer.sv
module fg_busy_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  // R4
  grant_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);

  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));
endmodule

// File: rtl/fg_read_gate.sv
module fg_read_gate
  import fg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int RWW_LIMIT = 'hC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] flash_data_i,
  input  logic              stall_i,
  input  logic              rww_hidden_i,
  input  logic              cross_deny_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_viol_o
);
  fg_rd_e outcome;
  logic   addr_low;

  always_comb begin
    addr_low = rd_addr_i < ADDR_W'(RWW_LIMIT);
    if (!rd_req_i)                    outcome = RD_IDLE;
    else if (stall_i)                 outcome = RD_HIDDEN;
    else if (addr_low && rww_hidden_i) outcome = RD_HIDDEN;
    else if (cross_deny_i)            outcome = RD_DENIED;
    else                              outcome = RD_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '1;
      rd_viol_o  <= 1'b0;
    end else begin
      rd_valid_o <= (outcome == RD_OK);
      rd_data_o  <= (outcome == RD_OK) ? flash_data_i : '1;
      rd_viol_o  <= (outcome == RD_DENIED);
    end
  end

  // R6
  no_read_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> !$past(stall_i));

  // R10
  deny_not_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_viol_o |-> (!rd_valid_o && rd_data_o == '1));

  // R11
  invalid_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> (rd_data_o == '1));
endmodule

// File: rtl/flash_spm_guard.sv
module flash_spm_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int BOOT_MIN    = 128,
  parameter int RWW_LIMIT   = 'hC00,
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic [1:0]        boot_size,
  input  logic [1:0]        app_lock,
  input  logic [1:0]        boot_lock,
  input  logic              st_req,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              reen_req,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] flash_data,
  output logic              st_grant,
  output logic              st_err,
  output logic              busy,
  output logic              cpu_stall,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              violation
);
  localparam int NPROBE = 3;  // 0: pc, 1: store target, 2: read address

  logic [NPROBE-1:0][ADDR_W-1:0] probe_addr;
  logic [NPROBE-1:0]             probe_boot;

  assign probe_addr[0] = pc;
  assign probe_addr[1] = st_addr;
  assign probe_addr[2] = rd_addr;

  for (genvar i = 0; i < NPROBE; i++) begin : g_probe
    fg_region_decode #(
      .ADDR_W  (ADDR_W),
      .BOOT_MIN(BOOT_MIN)
    ) u_dec (
      .addr     (probe_addr[i]),
      .boot_size(boot_size),
      .in_boot  (probe_boot[i])
    );
  end

  logic     pc_boot;
  fg_lock_t app_l, boot_l, st_lock, rd_lock;
  logic     st_take, st_deny, st_clash, st_low;
  logic     reen_take, cross_deny;
  logic     busy_w;
  logic     tgt_low_q, rww_hidden_q;
  logic     st_grant_q, st_err_q, st_viol_q, rd_viol;

  always_comb begin
    pc_boot    = probe_boot[0];
    app_l      = fg_lock_t'(app_lock);
    boot_l     = fg_lock_t'(boot_lock);
    st_lock    = probe_boot[1] ? boot_l : app_l;
    rd_lock    = probe_boot[2] ? boot_l : app_l;
    st_low     = st_addr < ADDR_W'(RWW_LIMIT);
    st_clash   = st_req && busy_w;
    st_take    = st_req && !busy_w && pc_boot && st_lock.wr_open;
    st_deny    = st_req && !busy_w && pc_boot && !st_lock.wr_open;
    reen_take  = reen_req && pc_boot && !busy_w;
    cross_deny = (probe_boot[2] != pc_boot) && !rd_lock.rd_open;
  end

  fg_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start_i(st_take),
    .busy_o (busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_low_q    <= 1'b0;
      rww_hidden_q <= 1'b0;
      st_grant_q   <= 1'b0;
      st_err_q     <= 1'b0;
      st_viol_q    <= 1'b0;
    end else begin
      st_grant_q <= st_take;
      st_err_q   <= st_clash;
      st_viol_q  <= st_deny;
      if (st_take) tgt_low_q <= st_low;
      if (st_take && st_low) rww_hidden_q <= 1'b1;
      else if (reen_take)    rww_hidden_q <= 1'b0;
    end
  end

  fg_read_gate #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RWW_LIMIT(RWW_LIMIT)
  ) u_read (
    .clk         (clk),
    .rst         (rst),
    .rd_req_i    (rd_req),
    .rd_addr_i   (rd_addr),
    .flash_data_i(flash_data),
    .stall_i     (cpu_stall),
    .rww_hidden_i(rww_hidden_q),
    .cross_deny_i(cross_deny),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .rd_viol_o   (rd_viol)
  );

  assign st_grant  = st_grant_q;
  assign st_err    = st_err_q;
  assign busy      = busy_w;
  assign cpu_stall = busy_w && !tgt_low_q;
  assign violation = st_viol_q || rd_viol;

  // R7
  hidden_during_low_op_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_w && !cpu_stall) |-> rww_hidden_q);

  // R8
  reen_only_from_boot_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rww_hidden_q) |-> $past(reen_req && pc_boot && !busy_w));

  // R2
  grant_from_boot_chk: assert property (@(posedge clk) disable iff (rst)
    st_grant |-> $past(pc_boot && st_req));

  // R4
  err_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    st_err |-> ($past(busy_w) && !st_grant));
endmodule

// File: tb/flash_spm_guard_test.sv
module flash_spm_guard_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pc = '0, st_addr = '0, rd_addr = '0;
  logic [1:0]  boot_size = 2'b11, app_lock = 2'b11, boot_lock = 2'b11;
  logic        st_req = 1'b0, reen_req = 1'b0, rd_req = 1'b0;
  logic [15:0] flash_data;
  logic        st_grant, st_err, busy, cpu_stall, rd_valid, violation;
  logic [15:0] rd_data;

  assign flash_data = {4'hA, rd_addr};

  always #4 clk = ~clk;  // 125 MHz

  flash_spm_guard #(.BUSY_CYCLES(N)) uut (
    .clk(clk), .rst(rst), .pc(pc), .boot_size(boot_size),
    .app_lock(app_lock), .boot_lock(boot_lock), .st_req(st_req),
    .st_addr(st_addr), .reen_req(reen_req), .rd_req(rd_req),
    .rd_addr(rd_addr), .flash_data(flash_data), .st_grant(st_grant),
    .st_err(st_err), .busy(busy), .cpu_stall(cpu_stall),
    .rd_valid(rd_valid), .rd_data(rd_data), .violation(violation));

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;
  string phase = "R12";

  // behavioural reference model
  int m_busy, m_cnt, m_low, m_hidden;
  int m_grant, m_err, m_rv, m_viol;
  int m_rd;

  function automatic int in_boot(int a, int bs);
    int start = 4096 - (128 << (3 - bs));
    return (a >= start) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_low = 0; m_hidden = 0;
      m_grant = 0; m_err = 0; m_rv = 0; m_viol = 0; m_rd = 'hFFFF;
    end else begin
      int pcb, lk, grant_now;
      pcb = in_boot(pc, boot_size);
      m_grant = 0; m_err = 0; m_viol = 0; m_rv = 0; m_rd = 'hFFFF;
      grant_now = 0;
      if (st_req) begin
        if (m_busy != 0) m_err = 1;
        else if (pcb != 0) begin
          lk = in_boot(st_addr, boot_size) ? boot_lock : app_lock;
          if ((lk & 1) == 0) m_viol = 1;
          else grant_now = 1;
        end
      end
      if (rd_req) begin
        if (m_busy != 0 && m_low == 0) ;
        else if (rd_addr < 'hC00 && m_hidden != 0) ;
        else begin
          lk = in_boot(rd_addr, boot_size) ? boot_lock : app_lock;
          if (in_boot(rd_addr, boot_size) != pcb && (lk & 2) == 0) m_viol = 1;
          else begin m_rv = 1; m_rd = flash_data; end
        end
      end
      if (reen_req && m_busy == 0 && pcb != 0) m_hidden = 0;
      if (m_busy != 0) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (grant_now != 0) begin
        m_grant = 1; m_busy = 1; m_cnt = N - 1;
        m_low = (st_addr < 'hC00) ? 1 : 0;
        if (m_low != 0) m_hidden = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int e_stall;
      e_stall = (m_busy != 0 && m_low == 0) ? 1 : 0;
      checks++;
      if (st_grant !== 1'(m_grant) || st_err !== 1'(m_err) || busy !== 1'(m_busy) ||
          cpu_stall !== 1'(e_stall) || rd_valid !== 1'(m_rv) ||
          rd_data !== 16'(m_rd) || violation !== 1'(m_viol)) begin
        errors++;
        $display("FAIL %s t=%0t act g%b e%b b%b s%b v%b d%h x%b exp g%0d e%0d b%0d s%0d v%0d d%h x%0d",
          phase, $time, st_grant, st_err, busy, cpu_stall, rd_valid, rd_data, violation,
          m_grant, m_err, m_busy, e_stall, m_rv, 16'(m_rd), m_viol);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic store(input logic [11:0] p, input logic [11:0] a);
    pc = p; st_addr = a; st_req = 1'b1; tick(); st_req = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    rd_addr = a; rd_req = 1'b1; tick(); rd_req = 1'b0;
  endtask

  task automatic reen(input logic [11:0] p);
    pc = p; reen_req = 1'b1; tick(); reen_req = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    tick(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    phase = "R12 reset state";
    tick(2);
    phase = "R11 read latency";
    pc = 12'h010; rd(12'h123); rd(12'hD00); tick(2);

    // boot region edges for every size setting
    for (int bs = 0; bs < 4; bs++) begin
      int start = 4096 - (128 << (3 - bs));
      boot_size = 2'(bs);
      phase = "R2 store from application region";
      store(12'(start - 1), 12'hE00); tick(3);
      phase = "R1 store at boot region start";
      store(12'(start), 12'hE00); tick(N + 2);
    end
    boot_size = 2'b11;

    phase = "R3 store into boot region";
    store(12'hF90, 12'hFC0); tick(N + 2);

    phase = "R4 store while busy";
    store(12'hF90, 12'hD00); store(12'hF90, 12'h100); tick(2);
    store(12'hF90, 12'hE00); tick(N + 2);

    phase = "R5 low-region operation keeps core running";
    store(12'hF90, 12'h200); rd(12'hD00); rd(12'hFF0);
    phase = "R7 low region hidden during operation";
    rd(12'h200); rd(12'h000); tick(N);
    phase = "R7 low region still hidden after operation";
    rd(12'h200); rd(12'hBFF);
    phase = "R8 re-enable from application ignored";
    reen(12'h100); rd(12'h200);
    phase = "R8 re-enable while busy ignored";
    store(12'hF90, 12'hD00); reen(12'hF90); tick(N);
    pc = 12'h100; rd(12'h300);
    phase = "R8 re-enable from boot region";
    reen(12'hF90); pc = 12'h100; rd(12'h300); rd(12'hBFF); tick(2);

    phase = "R6 high-region operation stalls core";
    store(12'hF90, 12'hC00); rd(12'hD00); rd(12'h100); tick(N);
    rd(12'hD00); tick(2);

    phase = "R9 application store lock";
    app_lock = 2'b10; store(12'hF90, 12'h100); tick(2);
    store(12'hF90, 12'hFA0); tick(N + 2);
    phase = "R9 boot store lock";
    app_lock = 2'b11; boot_lock = 2'b00; store(12'hF90, 12'hF80); tick(2);
    boot_lock = 2'b11;

    phase = "R10 cross-region read lock";
    app_lock = 2'b00; pc = 12'hF90; rd(12'hD00); pc = 12'h100; rd(12'hD00);
    app_lock = 2'b11; boot_lock = 2'b01; pc = 12'h100; rd(12'hF80);
    pc = 12'hF90; rd(12'hF80);
    phase = "R10 read lock leaves stores open";
    store(12'hF90, 12'hF80); tick(N + 2);
    boot_lock = 2'b11; tick(2);

    phase = "R1 randomized mix";
    for (int i = 0; i < 600; i++) begin
      pc        = ($urandom_range(0, 3) != 0) ? 12'($urandom_range(3072, 4095)) : 12'($urandom);
      st_req    = ($urandom_range(0, 9) == 0);
      st_addr   = 12'($urandom);
      reen_req  = ($urandom_range(0, 7) == 0);
      rd_req    = ($urandom_range(0, 1) == 0);
      rd_addr   = 12'($urandom);
      if ($urandom_range(0, 30) == 0) begin
        boot_size = 2'($urandom); app_lock = 2'($urandom); boot_lock = 2'($urandom);
      end
      tick();
    end
    st_req = 1'b0; reen_req = 1'b0; rd_req = 1'b0;
    tick(N + 2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule